// File: doc/BRIEF.md
# Asynchronous Memory Access Phase Sequencer

This block drives the control strobes for one region of external asynchronous SRAM or NOR memory. It takes one read or write request at a time and splits the access into timed phases: address setup, an optional multiplexed address hold, data, data hold and bus turnaround. During these phases it drives chip select, output enable, write enable, address valid and write-data drive. The length of each phase, in kernel-clock cycles, comes from a 25-bit timing word held in a configuration register.

A request is accepted only while `ready_o` is high. At acceptance the block latches the address, the write data and a snapshot of the timing word, so the whole access runs on one set of timings. Read data is captured on the last cycle of the data phase. `done_o` pulses on the last turnaround cycle, and `ready_o` returns on the cycle after it.

Top module: `amem_phase_seq`

## Requirements
- R1: Timing word field positions: bits [3:0] setup count, [7:4] hold count, [15:8] data count, [19:16] turnaround count, [21:20] mode (0=A, 1=B, 2=C, 3=D), [23:22] data-hold count, [24] multiplexed-address enable. The word loads when `cfg_we_i` is high. After reset it reads setup=15, hold=15, data=255, turnaround=15, with every other field 0, and `ready_o` is high with all strobes and `done_o` low.
- R2: The address-setup phase lasts exactly the setup count in cycles, and a count of 0 leaves it out. `adv_o` is high in every setup and hold cycle and in no other cycle.
- R3: The address-hold phase happens only when the multiplexed-address bit is set. It lasts the hold count in cycles, and a hold count of 0 acts as 1.
- R4: The data phase lasts the data count in cycles, and a count of 0 acts as 1. On a write, `we_o` is high for exactly the data phase. `mem_addr_o` carries the accepted address in every chip-select cycle, and `mem_wdata_o` carries the accepted write data in every write-enable cycle.
- R5: Data hold lasts the data-hold count on a read and that count plus 1 on a write. On a write, `dq_oe_o` is high for data plus data hold, and on a read it is never high.
- R6: Turnaround lasts the turnaround count plus 1 cycles, with `cs_o` low. `done_o` is high only in the final turnaround cycle, and `ready_o` is high on the next cycle.
- R7: `cs_o` is high in one unbroken interval per access, from the first setup cycle (or the first following phase if setup is skipped) to the last data-hold cycle.
- R8: On a read in mode A or C, `oe_o` is high only during the data phase. In mode B or D it is high from the first cycle of the access through the last data cycle. On a write `oe_o` is never high.
- R9: `rd_data_o` takes `mem_rdata_i` as sampled in the last data cycle of a read, and it holds that value through later writes.
- R10: Each access runs on the timing word that was held when it was accepted. Writes to the configuration during an access affect only later accesses.
- R11: `req_i` has no effect while `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Load timing word |
| cfg_word_i | input | 25 | Timing word |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Access address |
| req_wdata_i | input | DATA_W | Write data |
| ready_o | output | 1 | Idle, request can be taken |
| done_o | output | 1 | Access completion pulse |
| rd_data_o | output | DATA_W | Captured read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data |
| dq_oe_o | output | 1 | Write-data drive enable |
| cs_o | output | 1 | Chip select (active high) |
| oe_o | output | 1 | Output enable (active high) |
| we_o | output | 1 | Write enable (active high) |
| adv_o | output | 1 | Address valid (active high) |

## Verification
The bench builds the block with ADDR_W=24 and DATA_W=32. With those widths the memory model can return read data that combines the full address with a running count of chip-select cycles. A capture made in any cycle other than the last data cycle therefore gives a different low byte. The bench runs the slowest timing word after reset, zero fields that are skipped or clamped, every mode, and configuration writes and requests made while an access is in progress.

// File: rtl/amem_pkg.sv
`timescale 1ns/1ps
package amem_pkg;
  localparam int SETUP_W = 4;
  localparam int HOLD_W  = 4;
  localparam int DLEN_W  = 8;
  localparam int TURN_W  = 4;
  localparam int MODE_W  = 2;
  localparam int DHLD_W  = 2;
  localparam int CNT_W   = DLEN_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_AHOLD, PH_DATA, PH_DHOLD, PH_TURN
  } phase_e;

  typedef struct packed {
    logic              mux;
    logic [DHLD_W-1:0]  dhold;
    logic [MODE_W-1:0]  mode;
    logic [TURN_W-1:0]  turn;
    logic [DLEN_W-1:0]  data;
    logic [HOLD_W-1:0]  hold;
    logic [SETUP_W-1:0] setup;
  } timing_t;

  localparam int TIM_W = $bits(timing_t);

  localparam timing_t TIMING_RST = '{
    mux: 1'b0, dhold: '0, mode: '0,
    turn: '1, data: '1, hold: '1, setup: '1
  };
endpackage

// File: rtl/amem_timing_reg.sv
`timescale 1ns/1ps
module amem_timing_reg
  import amem_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [TIM_W-1:0] cfg_word_i,
  input  logic             accept_i,
  input  logic             idle_i,
  output timing_t          tim_o
);
  timing_t cfg_q, snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= TIMING_RST;
      snap_q <= TIMING_RST;
    end else begin
      if (cfg_we_i) cfg_q  <= timing_t'(cfg_word_i);
      if (accept_i) snap_q <= cfg_q;
    end
  end

  // on the accept cycle the live word is used, so the first phase load sees it
  assign tim_o = accept_i ? cfg_q : snap_q;

  assert_tim_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> (idle_i || $stable(tim_o)));
endmodule

// File: rtl/amem_phase_fsm.sv
`timescale 1ns/1ps
module amem_phase_fsm
  import amem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_we_i,
  input  timing_t           tim_i,
  output phase_e            phase_o,
  output logic              wr_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              last_o,
  output logic              accept_o,
  output logic              idle_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_eff, accept, idle, last;

  function automatic phase_e succ(phase_e ph, timing_t t, logic wr);
    phase_e nx;
    case (ph)
      PH_IDLE:  nx = (t.setup != '0) ? PH_SETUP : (t.mux ? PH_AHOLD : PH_DATA);
      PH_SETUP: nx = t.mux ? PH_AHOLD : PH_DATA;
      PH_AHOLD: nx = PH_DATA;
      PH_DATA:  nx = (wr || t.dhold != '0) ? PH_DHOLD : PH_TURN;
      PH_DHOLD: nx = PH_TURN;
      default:  nx = PH_IDLE;
    endcase
    return nx;
  endfunction

  // counter load value: phase length minus one
  function automatic logic [CNT_W-1:0] plen(phase_e ph, timing_t t, logic wr);
    logic [CNT_W-1:0] n;
    case (ph)
      PH_SETUP: n = CNT_W'(t.setup) - CNT_W'(1);
      PH_AHOLD: n = (t.hold == '0) ? '0 : CNT_W'(t.hold) - CNT_W'(1);
      PH_DATA:  n = (t.data == '0) ? '0 : CNT_W'(t.data) - CNT_W'(1);
      PH_DHOLD: n = wr ? CNT_W'(t.dhold) : CNT_W'(t.dhold) - CNT_W'(1);
      PH_TURN:  n = CNT_W'(t.turn);
      default:  n = '0;
    endcase
    return n;
  endfunction

  always_comb begin
    idle    = (phase_q == PH_IDLE);
    accept  = req_i && idle;
    last    = !idle && (cnt_q == '0);
    wr_eff  = accept ? req_we_i : wr_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (accept || last) begin
      phase_d = succ(phase_q, tim_i, wr_eff);
      cnt_d   = plen(phase_d, tim_i, wr_eff);
    end else if (!idle) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_eff;
    end
  end

  assign phase_o  = phase_q;
  assign wr_o     = wr_q;
  assign mode_o   = tim_i.mode;
  assign last_o   = last;
  assign accept_o = accept;
  assign idle_o   = idle;

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && cnt_q != '0) |=>
      (phase_q == $past(phase_q) && cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_turn_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TURN && cnt_q == '0) |=> phase_q == PH_IDLE);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !req_i) |=> phase_q == PH_IDLE);

  assert_busy_stays_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && phase_q != PH_TURN) |=> phase_q != PH_IDLE);
endmodule

// File: rtl/amem_strobe_gen.sv
`timescale 1ns/1ps
module amem_strobe_gen
  import amem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  phase_e            phase_i,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dq_oe_o,
  output logic              cs_o,
  output logic              oe_o,
  output logic              we_o,
  output logic              adv_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_q;
  logic              in_addr, in_data, in_dhold, in_turn, early_oe;

  always_comb begin
    in_addr  = (phase_i == PH_SETUP) || (phase_i == PH_AHOLD);
    in_data  = (phase_i == PH_DATA);
    in_dhold = (phase_i == PH_DHOLD);
    in_turn  = (phase_i == PH_TURN);
    early_oe = mode_i[0];   // modes B and D open the output early
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (in_data && last_i && !wr_i) rd_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign rd_data_o   = rd_q;
  assign cs_o        = in_addr || in_data || in_dhold;
  assign adv_o       = in_addr;
  assign we_o        = wr_i && in_data;
  assign oe_o        = !wr_i && (in_data || (early_oe && in_addr));
  assign dq_oe_o     = wr_i && (in_data || in_dhold);
  assign done_o      = in_turn && last_i;

  assert_oe_we_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(oe_o && we_o));

  assert_we_in_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (cs_o && dq_oe_o));

  assert_cs_off_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);

  assert_cs_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> in_turn);

  assert_rd_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> $stable(rd_data_o));
endmodule

// File: rtl/amem_phase_seq.sv
`timescale 1ns/1ps
module amem_phase_seq
  import amem_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TIM_W-1:0]  cfg_word_i,
  input  logic              req_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              dq_oe_o,
  output logic              cs_o,
  output logic              oe_o,
  output logic              we_o,
  output logic              adv_o
);
  timing_t           tim;
  phase_e            phase;
  logic              wr, last, accept, idle;
  logic [MODE_W-1:0] mode;

  amem_timing_reg u_tim (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_word_i,
    .accept_i (accept),
    .idle_i   (idle),
    .tim_o    (tim)
  );

  amem_phase_fsm u_fsm (
    .clk_i, .rst_ni, .req_i, .req_we_i,
    .tim_i    (tim),
    .phase_o  (phase),
    .wr_o     (wr),
    .mode_o   (mode),
    .last_o   (last),
    .accept_o (accept),
    .idle_o   (idle)
  );

  amem_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stb (
    .clk_i, .rst_ni,
    .accept_i    (accept),
    .req_addr_i, .req_wdata_i,
    .phase_i     (phase),
    .wr_i        (wr),
    .mode_i      (mode),
    .last_i      (last),
    .mem_rdata_i,
    .mem_addr_o, .mem_wdata_o, .rd_data_o,
    .dq_oe_o, .cs_o, .oe_o, .we_o, .adv_o, .done_o
  );

  assign ready_o = idle;

  assert_ready_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !(cs_o || oe_o || we_o || adv_o || dq_oe_o || done_o));
endmodule

// File: tb/amem_phase_seq_tb_top.sv
`timescale 1ns/1ps
module amem_phase_seq_tb_top;
  import amem_pkg::*;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [TIM_W-1:0] cfg_word_i = '0;
  logic          req_i = 1'b0, req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0, mem_rdata_i = '0;
  logic          ready_o, done_o, dq_oe_o, cs_o, oe_o, we_o, adv_o;
  logic [DW-1:0] rd_data_o, mem_wdata_o;
  logic [AW-1:0] mem_addr_o;

  always #2.5 clk_i = ~clk_i;

  amem_phase_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  typedef struct {
    int busy, cs, adv, oe, we, dq;
    logic [DW-1:0] rd, wd;
    logic [AW-1:0] addr;
    string tag;
  } exp_t;

  exp_t    sb_q[$];
  timing_t cfg_m;
  logic [DW-1:0] last_rd = '0;
  int n_checks = 0, n_err = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_x(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic timing_t mk(int s, int h, int d, int t, int m, int dh, int mx);
    timing_t w;
    w.setup = SETUP_W'(s); w.hold = HOLD_W'(h); w.data = DLEN_W'(d);
    w.turn = TURN_W'(t); w.mode = MODE_W'(m); w.dhold = DHLD_W'(dh); w.mux = mx[0];
    return w;
  endfunction

  task automatic cfg_write(timing_t w);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_word_i = w;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    cfg_m = w;
  endtask

  // driver: waits for ready, pushes the expected item, presents the request
  task automatic issue(logic wr, logic [AW-1:0] a, logic [DW-1:0] wd, string tag);
    exp_t e;
    int s, h, d, dh;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    s  = int'(cfg_m.setup);
    h  = cfg_m.mux ? ((cfg_m.hold == 0) ? 1 : int'(cfg_m.hold)) : 0;
    d  = (cfg_m.data == 0) ? 1 : int'(cfg_m.data);
    dh = wr ? int'(cfg_m.dhold) + 1 : int'(cfg_m.dhold);
    e.busy = s + h + d + dh + int'(cfg_m.turn) + 1;
    e.cs   = s + h + d + dh;
    e.adv  = s + h;
    e.we   = wr ? d : 0;
    e.dq   = wr ? d + dh : 0;
    e.oe   = wr ? 0 : (cfg_m.mode[0] ? s + h + d : d);
    if (!wr) last_rd = {a, 8'(s + h + d)};
    e.rd = last_rd; e.wd = wd; e.addr = a; e.tag = tag;
    sb_q.push_back(e);
    req_i = 1'b1; req_we_i = wr; req_addr_i = a; req_wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (!ready_o || sb_q.size() != 0) @(negedge clk_i);
  endtask

  // monitor
  int n_busy = 0, n_cs = 0, n_adv = 0, n_oe = 0, n_we = 0, n_dq = 0, n_rise = 0, n_bad = 0;
  logic cs_prev = 1'b0, rdy_chk = 1'b0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rdy_chk) chk("R6", "ready after done", int'(ready_o), 1);
      rdy_chk = 1'b0;
      if (!ready_o) begin
        n_busy++;
        n_cs += int'(cs_o); n_adv += int'(adv_o); n_oe += int'(oe_o);
        n_we += int'(we_o); n_dq += int'(dq_oe_o);
        if (cs_o && !cs_prev) n_rise++;
        if (sb_q.size() != 0) begin
          if (cs_o && mem_addr_o !== sb_q[0].addr) n_bad++;
          if (we_o && mem_wdata_o !== sb_q[0].wd) n_bad++;
        end
      end
      cs_prev = cs_o;
      mem_rdata_i = {mem_addr_o, n_cs[7:0]};
      if (done_o) begin
        if (sb_q.size() == 0) begin
          chk("R11", "unexpected access", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({"R6/", e.tag}, "busy cycles", n_busy, e.busy);
          chk({"R7/", e.tag}, "cs cycles", n_cs, e.cs);
          chk({"R7/", e.tag}, "cs intervals", n_rise, 1);
          chk({"R2/", e.tag}, "adv cycles", n_adv, e.adv);
          chk({"R8/", e.tag}, "oe cycles", n_oe, e.oe);
          chk({"R4/", e.tag}, "we cycles", n_we, e.we);
          chk({"R4/", e.tag}, "addr/wdata mismatches", n_bad, 0);
          chk({"R5/", e.tag}, "dq drive cycles", n_dq, e.dq);
          chk_x({"R9/", e.tag}, "read data", rd_data_o, e.rd);
        end
        n_busy = 0; n_cs = 0; n_adv = 0; n_oe = 0; n_we = 0; n_dq = 0; n_rise = 0; n_bad = 0;
        rdy_chk = 1'b1;
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_checks++; n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    report();
  end

  initial begin
    cfg_m = TIMING_RST;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "ready after reset", int'(ready_o), 1);
    chk("R1", "strobes after reset", int'({cs_o, oe_o, we_o, adv_o, dq_oe_o, done_o}), 0);
    chk_x("R1", "rd_data after reset", rd_data_o, '0);

    // R1: slowest default timing
    issue(1'b0, 24'hABCDEF, '0, "R1");
    wait_idle();

    // R5: data hold on read vs write, mode A
    cfg_write(mk(2, 3, 4, 1, 0, 2, 0));
    issue(1'b0, 24'h000111, '0, "R5");
    issue(1'b1, 24'h000222, 32'hDEAD_BEEF, "R5");
    wait_idle();

    // R3: zero fields, multiplexed hold clamped to one
    cfg_write(mk(0, 0, 0, 0, 0, 0, 1));
    issue(1'b0, 24'h000333, '0, "R3");
    issue(1'b1, 24'h000444, 32'h1234_5678, "R3");
    wait_idle();

    // R8: mode B, C, D
    cfg_write(mk(3, 2, 5, 2, 1, 1, 1));
    issue(1'b0, 24'h000555, '0, "R8");
    cfg_write(mk(3, 2, 5, 2, 2, 1, 1));
    issue(1'b0, 24'h000666, '0, "R8");
    cfg_write(mk(1, 4, 7, 3, 3, 3, 1));
    issue(1'b1, 24'h000777, 32'hCAFE_0001, "R8");
    issue(1'b0, 24'h000888, '0, "R8");
    wait_idle();

    // R10: config change mid-access
    cfg_write(mk(2, 1, 6, 1, 0, 0, 0));
    issue(1'b0, 24'h000999, '0, "R10");
    cfg_write(mk(5, 4, 3, 0, 1, 0, 1));
    issue(1'b0, 24'h000AAA, '0, "R10");
    wait_idle();

    // R11: requests during busy are ignored
    issue(1'b0, 24'h000BBB, '0, "R11");
    req_i = 1'b1; req_we_i = 1'b1; req_addr_i = 24'h00DEAD;
    while (!done_o) @(negedge clk_i);
    req_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk("R11", "idle after ignored request", int'(ready_o && !cs_o), 1);

    // R9: write leaves read data unchanged
    issue(1'b1, 24'h000CCC, 32'h0BAD_F00D, "R9");
    wait_idle();
    chk("R10", "scoreboard drained", sb_q.size(), 0);
    report();
  end
endmodule